// File: doc/BRIEF.md
# Reset-on-Read Performance Counter Bank

This block keeps two performance-monitor counts for a T1 framer and serves them over a byte-wide register read bus. The first is an 8-bit count of transmit slip events. A slip event is one frame that the transmit slip buffer repeats or drops. The second is a 16-bit count of receive excessive-zero violations, which software sees as an upper byte and a lower byte. Each count holds the number of events since it was last read, and reading a count clears it.

Events arrive as single-cycle pulses. Software issues a one-cycle read strobe with an address, and the byte appears on the data output in the next cycle.

For the wide count, software reads the upper byte first. That read copies all 16 bits into a shadow register. The lower-byte read that follows returns the shadow's low byte and clears the live count, so the two bytes always come from the same instant. Both counts stop at all-ones instead of wrapping. An event that lands in the same cycle as a clearing read is kept in the new count.

Top module: `pmon_counter_bank`

## Requirements
- R1: While reset is held and right after it is released, `rd_data_o` is 0x00 and reads of all three mapped addresses return 0x00.
- R2: Each cycle with `slip_evt_i` high adds one to the slip count. A read of address 0x090F returns that count on `rd_data_o` in the cycle after the strobe, and the count then restarts at zero.
- R3: A slip event in the same cycle as a slip-count read is not lost. The read returns the old count and the new count is 1.
- R4: The slip count stops at 0xFF and does not wrap.
- R5: Each cycle with `ezv_evt_i` high adds one to the 16-bit violation count. A read of 0x0910 returns bits 15:8 of the count and latches all 16 bits into the shadow register.
- R6: A read of 0x0911 that follows an upper-byte read returns bits 7:0 of the latched value, even if the count moved in between, and sets the live count to zero.
- R7: A read of 0x0911 with no upper-byte read since the last lower-byte read returns the shadow's low byte and leaves the live count unchanged.
- R8: The 16-bit count stops at 0xFFFF and does not wrap.
- R9: A read of any other address returns 0x00 and changes no count, shadow or arming state.
- R10: A violation event in the same cycle as a clearing lower-byte read leaves the live count at 1.
- R11: `rd_data_o` changes only in the cycle after a read strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slip_evt_i | input | 1 | One-cycle pulse per transmit slip |
| ezv_evt_i | input | 1 | One-cycle pulse per excessive-zero violation |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 16 | Register read address |
| rd_data_o | output | 8 | Read data, registered |

## Verification
The embedded properties are checked on every cycle. They cover saturation holding, a clear with a coincident event loading one, the shadow capturing the live count on an upper-byte read, an armed lower-byte read zeroing the count, an unarmed one leaving it alone, unmapped reads returning zero, and read data holding between strobes. Only the bench scenarios can show that a whole sequence returns the right bytes: counts built from event trains, a shadow that stays stable while the live count keeps moving, arming that survives and then lapses across a read pair, and saturation reached only after tens of thousands of events.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_SLIP   = 2'd1,
    SEL_EZV_HI = 2'd2,
    SEL_EZV_LO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pmon_decode.sv
module pmon_decode
  import pmon_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SLIP_ADDR   = 'h090F,
  parameter int unsigned EZV_HI_ADDR = 'h0910,
  parameter int unsigned EZV_LO_ADDR = 'h0911
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(SLIP_ADDR))        sel_o = SEL_SLIP;
    else if (addr_i == ADDR_W'(EZV_HI_ADDR)) sel_o = SEL_EZV_HI;
    else if (addr_i == ADDR_W'(EZV_LO_ADDR)) sel_o = SEL_EZV_LO;
    else                                      sel_o = SEL_NONE;
  end
endmodule

// File: rtl/pmon_sat_counter.sv
module pmon_sat_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= inc_i ? CNT_ONE : '0;  // keep coincident event
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);  // R4 R8
  AST_CLR_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == CNT_ONE);  // R3 R10
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);  // R2 R5
endmodule

// File: rtl/pmon_counter_bank.sv
module pmon_counter_bank
  import pmon_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SLIP_W      = 8,
  parameter int unsigned EZV_W       = 16,
  parameter int unsigned SLIP_ADDR   = 'h090F,
  parameter int unsigned EZV_HI_ADDR = 'h0910,
  parameter int unsigned EZV_LO_ADDR = 'h0911
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slip_evt_i,
  input  logic              ezv_evt_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned HI_LSB = EZV_W - DATA_W;

  reg_sel_e          rd_sel;
  logic [SLIP_W-1:0] slip_cnt;
  logic [EZV_W-1:0]  ezv_cnt;
  logic [EZV_W-1:0]  shadow_q;
  logic              armed_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              slip_clr, hi_rd, lo_rd, ezv_clr;

  pmon_decode #(
    .ADDR_W(ADDR_W), .SLIP_ADDR(SLIP_ADDR),
    .EZV_HI_ADDR(EZV_HI_ADDR), .EZV_LO_ADDR(EZV_LO_ADDR)
  ) u_decode (
    .addr_i(rd_addr_i),
    .sel_o (rd_sel)
  );

  assign slip_clr = rd_en_i && rd_sel == SEL_SLIP;
  assign hi_rd    = rd_en_i && rd_sel == SEL_EZV_HI;
  assign lo_rd    = rd_en_i && rd_sel == SEL_EZV_LO;
  assign ezv_clr  = lo_rd && armed_q;  // clear only after a paired upper read

  pmon_sat_counter #(.WIDTH(SLIP_W)) u_slip_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(slip_evt_i), .clr_i(slip_clr), .cnt_o(slip_cnt)
  );

  pmon_sat_counter #(.WIDTH(EZV_W)) u_ezv_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ezv_evt_i), .clr_i(ezv_clr), .cnt_o(ezv_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      armed_q  <= 1'b0;
    end else if (hi_rd) begin
      shadow_q <= ezv_cnt;
      armed_q  <= 1'b1;
    end else if (lo_rd) begin
      armed_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_q <= '0;
    else if (rd_en_i) begin
      unique case (rd_sel)
        SEL_SLIP:   rd_data_q <= DATA_W'(slip_cnt);
        SEL_EZV_HI: rd_data_q <= ezv_cnt[EZV_W-1:HI_LSB];
        SEL_EZV_LO: rd_data_q <= shadow_q[DATA_W-1:0];
        default:    rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_data_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel == SEL_NONE) |=> rd_data_o == '0);  // R9
  AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel == SEL_NONE) |=> $stable(shadow_q) && $stable(armed_q));  // R9
  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |=> shadow_q == $past(ezv_cnt) && armed_q);  // R5
  AST_ARMED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd && armed_q && !ezv_evt_i) |=> ezv_cnt == '0);  // R6
  AST_UNARMED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd && !armed_q && !ezv_evt_i) |=> ezv_cnt == $past(ezv_cnt));  // R7
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));  // R11
endmodule

// File: tb/sim_pmon_counter_bank.sv
module sim_pmon_counter_bank;
  typedef struct packed {
    logic        slip;
    logic        ezv;
    logic        rd;
    logic [15:0] addr;
    logic        chk;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  // slip, ezv, rd, addr, chk, exp, requirement number
  localparam vec_t VEC [0:18] = '{
    {1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd2},
    {1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd2},
    {1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd2},
    {1'b0, 1'b0, 1'b1, 16'h090F, 1'b1, 8'h03, 8'd2},  // R2 count
    {1'b0, 1'b0, 1'b1, 16'h090F, 1'b1, 8'h00, 8'd2},  // R2 cleared
    {1'b1, 1'b0, 1'b1, 16'h090F, 1'b1, 8'h00, 8'd3},  // R3 old value
    {1'b0, 1'b0, 1'b1, 16'h090F, 1'b1, 8'h01, 8'd3},  // R3 event kept
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd5},
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd5},
    {1'b0, 1'b0, 1'b1, 16'h0910, 1'b1, 8'h00, 8'd5},  // R5 upper byte
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd6},
    {1'b0, 1'b0, 1'b1, 16'h0911, 1'b1, 8'h02, 8'd6},  // R6 latched low
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00, 8'd7},
    {1'b0, 1'b0, 1'b1, 16'h0911, 1'b1, 8'h02, 8'd7},  // R7 unarmed read
    {1'b0, 1'b0, 1'b1, 16'h0910, 1'b1, 8'h00, 8'd7},
    {1'b0, 1'b0, 1'b1, 16'h0911, 1'b1, 8'h01, 8'd7},  // R7 live count kept
    {1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 8'h00, 8'd9},  // R9 unmapped
    {1'b0, 1'b0, 1'b1, 16'h0912, 1'b1, 8'h00, 8'd9},  // R9 unmapped
    {1'b0, 1'b0, 1'b1, 16'h090F, 1'b1, 8'h01, 8'd9}   // R9 no side effect
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slip_evt = 1'b0, ezv_evt = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pmon_counter_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .slip_evt_i(slip_evt), .ezv_evt_i(ezv_evt),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic r, input logic [15:0] a);
    slip_evt = s; ezv_evt = e; rd_en = r; rd_addr = a;
    @(negedge clk);
    slip_evt = 1'b0; ezv_evt = 1'b0; rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic rd(input logic [15:0] a, input string req, input logic [7:0] exp);
    cyc(1'b0, 1'b0, 1'b1, a);
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(16'h090F, "R1", 8'h00);
    rd(16'h0910, "R1", 8'h00);
    rd(16'h0911, "R1", 8'h00);

    for (int i = 0; i < $size(VEC); i++) begin
      cyc(VEC[i].slip, VEC[i].ezv, VEC[i].rd, VEC[i].addr);
      if (VEC[i].chk) check($sformatf("R%0d", VEC[i].req), rd_data, VEC[i].exp);
    end

    // R11: data holds across idle cycles and events
    cyc(1'b1, 1'b1, 1'b0, 16'h0000);
    cyc(1'b0, 1'b0, 1'b0, 16'h0911);
    check("R11", rd_data, 8'h01);
    rd(16'h090F, "R11", 8'h01);  // drains slip count

    // R4: slip saturation
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0000);
    rd(16'h090F, "R4", 8'hFF);
    rd(16'h090F, "R4", 8'h00);

    // drain violation count (1 from R11 step)
    rd(16'h0910, "R5", 8'h00);
    rd(16'h0911, "R5", 8'h01);

    // R5/R6: upper byte nonzero, count keeps moving after latch
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b1, 1'b0, 16'h0000);
    rd(16'h0910, "R5", 8'h01);
    cyc(1'b0, 1'b1, 1'b0, 16'h0000);
    rd(16'h0911, "R6", 8'h2C);
    rd(16'h0910, "R6", 8'h00);
    rd(16'h0911, "R6", 8'h00);

    // R10: event coincident with clearing lower read
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 16'h0000);
    rd(16'h0910, "R10", 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 16'h0911);
    check("R10", rd_data, 8'h05);
    rd(16'h0910, "R10", 8'h00);
    rd(16'h0911, "R10", 8'h01);

    // R8: 16-bit saturation
    for (int i = 0; i < 65540; i++) cyc(1'b0, 1'b1, 1'b0, 16'h0000);
    rd(16'h0910, "R8", 8'hFF);
    rd(16'h0911, "R8", 8'hFF);
    rd(16'h0910, "R8", 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule